// File: doc/BRIEF.md
# Multiplexed External Memory Interface

This block connects a processor's register bus to external SRAM or flash over a narrow shared bus. Software never drives the external pins directly. It writes a word into a data register, or sets an address and asks for a read, and the block then runs a sequence of byte-wide external cycles. Each external cycle has an address phase and a data phase. In the address phase the latch strobe is high and the shared pins carry the low address byte, while dedicated pins carry the upper address bits. In the data phase an active-low read or write strobe is held for a selectable number of clocks.

A word may be 8, 16 or 24 bits long. It is moved least significant part first, at consecutive external addresses. In DRAM mode the lane is 4 bits wide and a word is 16 or 24 bits. In that mode a divider also produces a periodic refresh request, with sixteen possible periods. Completion can be polled through a sticky done flag or signalled by a level interrupt. After every transfer the stored address moves past the word, so a stream of words needs no address rewrites.

Top module: `xmem_ctrl`

## Requirements
- R1: After reset the latch strobe is low, both data strobes are high, the shared pins are not driven, the interrupt and the refresh request are low, and all four registers read as zero.
- R2: Every external cycle starts with exactly one clock in which the latch strobe is high, the shared pins are driven with address bits 7:0 and the upper pins carry address bits 21:8.
- R3: The data strobe of each external cycle stays low for (timing code + 1) clocks, where the timing code is control bits 3:2. The read and write strobes are never low together, and neither is low while the latch strobe is high.
- R4: A write to register 0 while idle starts a write. The word's lanes are driven on the shared pins, least significant lane first, during the write strobe.
- R5: The word-length code in control bits 1:0 gives 1, 2 or 3 byte cycles for codes 0, 1 and 2; code 3 acts as code 2. The cycles use consecutive addresses, which wrap at 22 bits. After the transfer, register 2 holds the start address plus the number of cycles.
- R6: When control bit 4 is 0, a write to register 2 loads the address and starts a read there. When it is 1, a write to register 2 only loads the address, and a read access to register 1 starts a read at the stored address while returning the previous word.
- R7: During a read the shared pins are not driven. The input lane is captured on the last strobe clock and placed least significant first, and the assembled word is readable at register 1 once done is set.
- R8: Status bit 16 (busy) is high from the clock after the triggering access to the end of the last strobe clock, which is cycles x (1 + strobe clocks) clocks. Status bit 17 (done) is then set. Done is cleared by a new start or by writing control bit 12 as 1. The interrupt equals done AND control bit 5.
- R9: While busy, a write to register 0, a write to register 2, or a triggering read of register 1 is ignored: no register changes and no cycle is added. Such an access sets the sticky error bit 18, which is cleared by writing control bit 13 as 1.
- R10: With control bit 6 set (DRAM mode), lanes are 4 bits wide on pins 3:0. A 16-bit word (length code 0 or 1) takes 4 cycles and a 24-bit word takes 6 cycles.
- R11: In DRAM mode the refresh request pulses for one clock every (D + 1) x REF_STEP clocks, where D is control bits 10:7. It never pulses in SRAM mode.
- R12: Configuration bits 10:0 change only when a control write arrives while idle. A control write during a transfer leaves them unchanged and does not set the error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 write data, 1 read data, 2 address, 3 control/status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only matters for register 1) |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for the selected register (combinational) |
| irq | output | 1 | Completion interrupt, level |
| xm_ale | output | 1 | Address latch strobe |
| xm_rd_n | output | 1 | Read strobe, active low |
| xm_wr_n | output | 1 | Write strobe, active low |
| xm_ad_out | output | 8 | Shared address/data pins, outgoing value |
| xm_ad_oe | output | 1 | Output enable for the shared pins |
| xm_ad_in | input | 8 | Shared address/data pins, incoming value |
| xm_addr_hi | output | 14 | Address bits 21:8 |
| refresh_req | output | 1 | DRAM refresh request pulse |

## Verification
A wrong lane counter or a wrong strobe counter shows up on the external pins within the same word. The bench would see an extra or missing latch pulse, a strobe that is one clock too long or too short, or a byte at the wrong address. The same fault also shows up on the register side, because the busy time and the advanced address both come out wrong as soon as the transfer ends. A fault in the busy guard shows up on the very next access made during a transfer: the error bit fails to rise, or the pins show a second word. Refresh divider faults appear as a wrong spacing between two consecutive request pulses.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int XM_ADDR_W = 22;
  localparam int XM_BUS_W  = 8;
  localparam int XM_NIB_W  = 4;
  localparam int XM_WORD_W = 24;
  localparam int XM_HI_W   = XM_ADDR_W - XM_BUS_W;
  localparam int XM_CFG_W  = 11;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_ADDR = 2'd1,
    XS_STRB = 2'd2
  } xm_state_t;

  typedef struct packed {
    logic [3:0] ref_div;
    logic       dram;
    logic       irq_en;
    logic       rd_on_data;
    logic [1:0] timing;
    logic [1:0] wlen;
  } xm_cfg_t;

  // number of external cycles that make up one word
  function automatic logic [2:0] units_per_word(input logic [1:0] wlen, input logic dram);
    if (dram) return (wlen >= 2'd2) ? 3'd6 : 3'd4;
    if (wlen == 2'd0) return 3'd1;
    if (wlen == 2'd1) return 3'd2;
    return 3'd3;
  endfunction

  // clocks of strobe-low time for a timing code
  function automatic logic [2:0] strobe_len(input logic [1:0] timing);
    return {1'b0, timing} + 3'd1;
  endfunction

  // lane idx of a word, zero-extended to the pin width
  function automatic logic [XM_BUS_W-1:0] lane_out(input logic [XM_WORD_W-1:0] word,
                                                   input logic [2:0] idx, input logic dram);
    logic [XM_WORD_W-1:0] sh;
    sh = dram ? (word >> (32'(idx) * XM_NIB_W)) : (word >> (32'(idx) * XM_BUS_W));
    return dram ? {{(XM_BUS_W-XM_NIB_W){1'b0}}, sh[XM_NIB_W-1:0]} : sh[XM_BUS_W-1:0];
  endfunction

  // place an incoming lane into lane idx of a word
  function automatic logic [XM_WORD_W-1:0] lane_in(input logic [XM_WORD_W-1:0] word,
                                                   input logic [2:0] idx, input logic dram,
                                                   input logic [XM_BUS_W-1:0] lane);
    logic [XM_WORD_W-1:0] m;
    logic [XM_WORD_W-1:0] v;
    int sh;
    sh = dram ? 32'(idx) * XM_NIB_W : 32'(idx) * XM_BUS_W;
    m  = dram ? XM_WORD_W'((1 << XM_NIB_W) - 1) : XM_WORD_W'((1 << XM_BUS_W) - 1);
    v  = {{(XM_WORD_W-XM_BUS_W){1'b0}}, lane} & m;
    return (word & ~(m << sh)) | (v << sh);
  endfunction
endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_wr,
  input  logic [XM_ADDR_W-1:0] start_addr,
  input  logic [XM_WORD_W-1:0] start_word,
  input  logic [1:0]           wlen,
  input  logic [1:0]           timing,
  input  logic                 dram,
  input  logic [XM_BUS_W-1:0]  ad_in,
  output logic                 busy,
  output logic                 done_evt,
  output logic                 unit_end,
  output logic [XM_WORD_W-1:0] rd_word,
  output logic [XM_HI_W-1:0]   addr_hi,
  output logic [XM_BUS_W-1:0]  ad_out,
  output logic                 ad_oe,
  output logic                 ale,
  output logic                 rd_n,
  output logic                 wr_n
);
  xm_state_t            state;
  logic                 is_wr;
  logic                 dram_q;
  logic [XM_ADDR_W-1:0] base;
  logic [XM_WORD_W-1:0] word;
  logic [2:0]           nunits;
  logic [2:0]           tlen;
  logic [2:0]           uidx;
  logic [2:0]           tcnt;
  logic [XM_ADDR_W-1:0] cur_addr;
  logic                 in_strb;

  assign cur_addr = base + XM_ADDR_W'(uidx);
  assign in_strb  = (state == XS_STRB);
  assign unit_end = in_strb && (tcnt == tlen - 3'd1);
  assign done_evt = unit_end && (uidx == nunits - 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= XS_IDLE;
      is_wr   <= 1'b0;
      dram_q  <= 1'b0;
      base    <= '0;
      word    <= '0;
      nunits  <= 3'd1;
      tlen    <= 3'd1;
      uidx    <= '0;
      tcnt    <= '0;
      rd_word <= '0;
    end else begin
      case (state)
        XS_IDLE: if (start) begin
          state  <= XS_ADDR;
          is_wr  <= start_wr;
          base   <= start_addr;
          word   <= start_word;
          nunits <= units_per_word(wlen, dram);
          tlen   <= strobe_len(timing);
          dram_q <= dram;
          uidx   <= '0;
          tcnt   <= '0;
          if (!start_wr) rd_word <= '0;
        end
        XS_ADDR: begin
          state <= XS_STRB;
          tcnt  <= '0;
        end
        XS_STRB: begin
          if (unit_end) begin
            if (!is_wr) rd_word <= lane_in(rd_word, uidx, dram_q, ad_in);
            if (done_evt) state <= XS_IDLE;
            else begin
              state <= XS_ADDR;
              uidx  <= uidx + 3'd1;
            end
          end else begin
            tcnt <= tcnt + 3'd1;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign busy    = (state != XS_IDLE);
  assign ale     = (state == XS_ADDR);
  assign addr_hi = busy ? cur_addr[XM_ADDR_W-1:XM_BUS_W] : '0;
  assign ad_out  = ale ? cur_addr[XM_BUS_W-1:0]
                 : (in_strb && is_wr) ? lane_out(word, uidx, dram_q) : '0;
  assign ad_oe   = ale || (in_strb && is_wr);
  assign rd_n    = !(in_strb && !is_wr);
  assign wr_n    = !(in_strb && is_wr);
endmodule

// File: rtl/xmem_regs.sv
module xmem_regs
  import xmem_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           sel,
  input  logic                 wr,
  input  logic                 rd,
  input  logic [XM_WORD_W-1:0] wdata,
  input  logic                 busy,
  input  logic                 done_evt,
  input  logic [XM_WORD_W-1:0] rd_word,
  output xm_cfg_t              cfg,
  output logic                 start,
  output logic                 start_wr,
  output logic [XM_ADDR_W-1:0] start_addr,
  output logic [XM_WORD_W-1:0] rdata,
  output logic                 done,
  output logic                 err,
  output logic                 ign_evt,
  output logic                 irq
);
  localparam logic [1:0] SEL_DWR = 2'd0;
  localparam logic [1:0] SEL_DRD = 2'd1;
  localparam logic [1:0] SEL_OFS = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;
  localparam int BIT_CLR_DONE = 12;
  localparam int BIT_CLR_ERR  = 13;
  localparam int PAD_W = XM_WORD_W - XM_ADDR_W;

  logic [XM_WORD_W-1:0] dwr_q;
  logic [XM_ADDR_W-1:0] offset;
  logic wr_dwr, wr_ofs, rd_drd, wr_ctl, trig_rd, touch;

  assign wr_dwr  = wr && (sel == SEL_DWR);
  assign wr_ofs  = wr && (sel == SEL_OFS);
  assign wr_ctl  = wr && (sel == SEL_CTL);
  assign rd_drd  = rd && (sel == SEL_DRD);
  assign trig_rd = (wr_ofs && !cfg.rd_on_data) || (rd_drd && cfg.rd_on_data);
  assign touch   = wr_dwr || wr_ofs || (rd_drd && cfg.rd_on_data);

  assign ign_evt    = busy && touch;
  assign start      = !busy && (wr_dwr || trig_rd);
  assign start_wr   = wr_dwr;
  assign start_addr = wr_ofs ? wdata[XM_ADDR_W-1:0] : offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwr_q  <= '0;
      offset <= '0;
      cfg    <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (wr_dwr && !busy) dwr_q <= wdata;
      if (wr_ofs && !busy) offset <= wdata[XM_ADDR_W-1:0];
      else if (done_evt)  offset <= offset + XM_ADDR_W'(units_per_word(cfg.wlen, cfg.dram));
      if (wr_ctl && !busy) cfg <= wdata[XM_CFG_W-1:0];
      if (start)                              done <= 1'b0;
      else if (done_evt)                      done <= 1'b1;
      else if (wr_ctl && wdata[BIT_CLR_DONE]) done <= 1'b0;
      if (ign_evt)                            err <= 1'b1;
      else if (wr_ctl && wdata[BIT_CLR_ERR])  err <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      SEL_DWR: rdata = dwr_q;
      SEL_DRD: rdata = rd_word;
      SEL_OFS: rdata = {{PAD_W{1'b0}}, offset};
      default: rdata = {5'b0, err, done, busy, 5'b0, cfg};
    endcase
  end

  assign irq = done && cfg.irq_en;
endmodule

// File: rtl/xmem_refresh.sv
module xmem_refresh #(
  parameter int REF_STEP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic [3:0] div,
  output logic       req
);
  localparam int CW = $clog2(16 * REF_STEP) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] period_m1;

  assign period_m1 = CW'((32'(div) + 32'd1) * 32'(REF_STEP) - 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (!enable) begin
      cnt <= '0;
      req <= 1'b0;
    end else if (cnt >= period_m1) begin
      cnt <= '0;
      req <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/xmem_ctrl.sv
module xmem_ctrl
  import xmem_pkg::*;
#(
  parameter int REF_STEP = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           reg_sel,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [XM_WORD_W-1:0] reg_wdata,
  output logic [XM_WORD_W-1:0] reg_rdata,
  output logic                 irq,
  output logic                 xm_ale,
  output logic                 xm_rd_n,
  output logic                 xm_wr_n,
  output logic [XM_BUS_W-1:0]  xm_ad_out,
  output logic                 xm_ad_oe,
  input  logic [XM_BUS_W-1:0]  xm_ad_in,
  output logic [XM_HI_W-1:0]   xm_addr_hi,
  output logic                 refresh_req
);
  xm_cfg_t              cfg_w;
  logic                 start_w, start_wr_w, busy_w, done_evt_w, unit_end_w;
  logic                 done_w, err_w, ign_evt_w;
  logic [XM_ADDR_W-1:0] start_addr_w;
  logic [XM_WORD_W-1:0] rd_word_w;

  xmem_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(reg_sel), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
    .busy(busy_w), .done_evt(done_evt_w), .rd_word(rd_word_w), .cfg(cfg_w),
    .start(start_w), .start_wr(start_wr_w), .start_addr(start_addr_w), .rdata(reg_rdata),
    .done(done_w), .err(err_w), .ign_evt(ign_evt_w), .irq(irq)
  );

  xmem_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .start_wr(start_wr_w),
    .start_addr(start_addr_w), .start_word(reg_wdata), .wlen(cfg_w.wlen),
    .timing(cfg_w.timing), .dram(cfg_w.dram), .ad_in(xm_ad_in), .busy(busy_w),
    .done_evt(done_evt_w), .unit_end(unit_end_w), .rd_word(rd_word_w),
    .addr_hi(xm_addr_hi), .ad_out(xm_ad_out), .ad_oe(xm_ad_oe), .ale(xm_ale),
    .rd_n(xm_rd_n), .wr_n(xm_wr_n)
  );

  xmem_refresh #(.REF_STEP(REF_STEP)) u_ref (
    .clk(clk), .rst_n(rst_n), .enable(cfg_w.dram), .div(cfg_w.ref_div), .req(refresh_req)
  );
endmodule

// File: rtl/xmem_chk.sv
module xmem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic        ad_oe,
  input logic        busy,
  input logic        done,
  input logic        done_evt,
  input logic        unit_end,
  input logic        irq,
  input logic        err,
  input logic        ign_evt,
  input logic        refresh_req,
  input logic [10:0] cfg_bits
);
  // R2
  ale_one_clock_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale);
  // R2
  ale_drives_pins_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |-> ad_oe);
  // R3
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
  // R3
  no_strobe_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (rd_n && wr_n));
  // R3
  strobe_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));
  // R4
  write_drives_pins_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> ad_oe);
  // R7
  read_releases_pins_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe);
  // R8
  busy_ends_chk: assert property (@(posedge clk) disable iff (!rst_n) done_evt |=> (!busy && done));
  // R8
  unit_end_in_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n) unit_end |-> !(rd_n && wr_n));
  // R8
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> done);
  // R9
  ignored_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n) ign_evt |=> err);
  // R11
  refresh_dram_only_chk: assert property (@(posedge clk) disable iff (!rst_n) refresh_req |-> $past(cfg_bits[6]));
  // R11
  refresh_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) refresh_req |=> !refresh_req);
  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(cfg_bits));
endmodule

bind xmem_ctrl xmem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(xm_ale), .rd_n(xm_rd_n), .wr_n(xm_wr_n), .ad_oe(xm_ad_oe),
  .busy(busy_w), .done(done_w), .done_evt(done_evt_w), .unit_end(unit_end_w), .irq(irq),
  .err(err_w), .ign_evt(ign_evt_w), .refresh_req(refresh_req), .cfg_bits(cfg_w)
);

// File: tb/sim_xmem_ctrl.sv
`timescale 1ns/1ps
module sim_xmem_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        irq, xm_ale, xm_rd_n, xm_wr_n, xm_ad_oe, refresh_req;
  logic [7:0]  xm_ad_out;
  logic [7:0]  ad_in_r = '0;
  logic [13:0] xm_addr_hi;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xmem_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .xm_ale(xm_ale),
    .xm_rd_n(xm_rd_n), .xm_wr_n(xm_wr_n), .xm_ad_out(xm_ad_out), .xm_ad_oe(xm_ad_oe),
    .xm_ad_in(ad_in_r), .xm_addr_hi(xm_addr_hi), .refresh_req(refresh_req)
  );

  // external memory model: content derived from the address
  function automatic logic [7:0] pat(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b01} ^ 8'h3C;
  endfunction

  function automatic int n_units(input logic [1:0] wl, input logic dr);
    if (dr) return wl[1] ? 6 : 4;
    return (wl == 2'd0) ? 1 : (wl == 2'd1) ? 2 : 3;
  endfunction

  function automatic logic [23:0] mk_ctl(input logic [3:0] dv, input logic dr, input logic ie,
                                         input logic rdd, input logic [1:0] tm, input logic [1:0] wl);
    return {13'b0, dv, dr, ie, rdd, tm, wl};
  endfunction

  // bus monitor: log every external cycle
  int          n_ale = 0;
  int          mi;
  logic [21:0] log_a [64];
  logic [7:0]  log_d [64];
  int          log_s [64];
  always @(negedge clk) begin
    if (xm_ale) begin
      mi = n_ale % 64;
      log_a[mi] = {xm_addr_hi, xm_ad_out};
      log_s[mi] = 0;
      log_d[mi] = 8'h00;
      ad_in_r = pat({xm_addr_hi, xm_ad_out});
      n_ale++;
    end
    if (!xm_wr_n || !xm_rd_n) begin
      mi = (n_ale + 63) % 64;
      log_s[mi]++;
      if (!xm_wr_n) log_d[mi] = xm_ad_out;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] s, input logic [23:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic bus_rd(input logic [1:0] s, output logic [23:0] d);
    @(negedge clk);
    reg_sel = s; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic peek(input logic [1:0] s, output logic [23:0] d);
    reg_sel = s;
    #1 d = reg_rdata;
    reg_sel = 2'd3;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    reg_sel = 2'd3;
    #1;
    while (reg_rdata[16] && cyc < 2000) begin
      cyc++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic ref_gap(output int g);
    g = 0;
    @(negedge clk);
    while (!refresh_req) @(negedge clk);
    @(negedge clk);
    g = 1;
    while (!refresh_req && g < 1000) begin
      @(negedge clk);
      g++;
    end
  endtask

  // {write, wlen, timing, dram, addr[21:0], word[23:0]}
  localparam logic [51:0] VEC [7] = '{
    {1'b1, 2'd2, 2'd0, 1'b0, 22'h3FFFFE, 24'hC3B2A1},
    {1'b1, 2'd0, 2'd3, 1'b0, 22'h012345, 24'h00007E},
    {1'b0, 2'd1, 2'd1, 1'b0, 22'h00ABCD, 24'h000000},
    {1'b0, 2'd2, 2'd2, 1'b0, 22'h2000FF, 24'h000000},
    {1'b1, 2'd1, 2'd0, 1'b1, 22'h000100, 24'h00BEEF},
    {1'b0, 2'd2, 2'd1, 1'b1, 22'h001000, 24'h000000},
    {1'b1, 2'd3, 2'd1, 1'b0, 22'h1ABCDE, 24'h5A6B7C}
  };

  logic [23:0] d, ctl, exp_w, last_rd;
  logic [21:0] a0;
  int cyc, n0, nu, tl, lw, g, pulses;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    #1;
    chk(xm_ale == 1'b0 && xm_rd_n && xm_wr_n && !xm_ad_oe, "R1 strobes idle",
        {28'b0, xm_ale, xm_rd_n, xm_wr_n, xm_ad_oe}, 32'h6);
    chk(!irq && !refresh_req, "R1 irq/refresh low", {30'b0, irq, refresh_req}, 0);
    for (int s = 0; s < 4; s++) begin
      peek(2'(s), d);
      chk(d == 24'h0, "R1 register reset value", d, 0);
    end

    // vector table
    last_rd = '0;
    for (int v = 0; v < 7; v++) begin
      a0  = VEC[v][45:24];
      nu  = n_units(VEC[v][50:49], VEC[v][46]);
      tl  = int'(VEC[v][48:47]) + 1;
      lw  = VEC[v][46] ? 4 : 8;
      ctl = mk_ctl(4'd0, VEC[v][46], 1'b0, VEC[v][51], VEC[v][48:47], VEC[v][50:49]);
      bus_wr(2'd3, ctl);
      if (VEC[v][51]) begin
        bus_wr(2'd2, {2'b0, a0});
        n0 = n_ale;
        bus_wr(2'd0, VEC[v][23:0]);
      end else begin
        n0 = n_ale;
        bus_wr(2'd2, {2'b0, a0});
      end
      wait_idle(cyc);
      chk(cyc == nu * (1 + tl), "R8 busy duration", cyc, nu * (1 + tl));
      chk(n_ale - n0 == nu, "R5 R10 cycle count", n_ale - n0, nu);
      exp_w = '0;
      for (int i = 0; i < nu; i++) begin
        logic [21:0] ea;
        logic [7:0]  el;
        ea = a0 + 22'(i);
        chk(log_a[(n0 + i) % 64] == ea, "R2 R5 cycle address", log_a[(n0 + i) % 64], ea);
        chk(log_s[(n0 + i) % 64] == tl, "R3 strobe length", log_s[(n0 + i) % 64], tl);
        if (VEC[v][51]) begin
          el = 8'((VEC[v][23:0] >> (i * lw)) & ((1 << lw) - 1));
          chk(log_d[(n0 + i) % 64] == el, "R4 R10 write lane", log_d[(n0 + i) % 64], el);
        end else begin
          el = VEC[v][46] ? (pat(ea) & 8'h0F) : pat(ea);
          exp_w = exp_w | (24'(el) << (i * lw));
        end
      end
      if (!VEC[v][51]) begin
        peek(2'd1, d);
        chk(d == exp_w, "R7 R10 read word", d, exp_w);
        last_rd = exp_w;
      end
      peek(2'd2, d);
      chk(d == {2'b0, a0 + 22'(nu)}, "R5 address advance", d, {2'b0, a0 + 22'(nu)});
      peek(2'd3, d);
      chk(d[17] == 1'b1, "R8 done set", d[17], 1);
    end

    // R6 read triggered by reading the data register
    ctl = mk_ctl(4'd0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1);
    bus_wr(2'd3, ctl);
    n0 = n_ale;
    bus_wr(2'd2, 24'h000040);
    peek(2'd3, d);
    chk(d[16] == 1'b0 && n_ale == n0, "R6 address write does not start", d[16], 0);
    bus_rd(2'd1, d);
    chk(d == last_rd, "R6 read returns previous word", d, last_rd);
    wait_idle(cyc);
    exp_w = {8'h00, pat(22'h41), pat(22'h40)};
    peek(2'd1, d);
    chk(d == exp_w, "R6 R7 data-read triggered word", d, exp_w);
    chk(log_a[n0 % 64] == 22'h40, "R6 read address", log_a[n0 % 64], 22'h40);

    // R9 accesses while busy, R12 control write while busy
    ctl = mk_ctl(4'd0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd2);
    bus_wr(2'd3, ctl);
    bus_wr(2'd2, 24'h000100);
    n0 = n_ale;
    bus_wr(2'd0, 24'h111111);
    bus_wr(2'd0, 24'h222222);
    bus_wr(2'd2, 24'h0003FF);
    bus_wr(2'd3, mk_ctl(4'd0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd2));
    wait_idle(cyc);
    chk(n_ale - n0 == 3, "R9 no extra cycles", n_ale - n0, 3);
    chk(log_d[(n0 + 2) % 64] == 8'h11, "R9 first word kept on pins", log_d[(n0 + 2) % 64], 8'h11);
    peek(2'd0, d);
    chk(d == 24'h111111, "R9 data register unchanged", d, 24'h111111);
    peek(2'd2, d);
    chk(d == 24'h000103, "R9 address register unchanged", d, 24'h000103);
    peek(2'd3, d);
    chk(d[18] == 1'b1, "R9 error set", d[18], 1);
    chk(d[3:2] == 2'd3, "R12 timing frozen during transfer", d[3:2], 3);
    bus_wr(2'd3, ctl | 24'h002000);
    peek(2'd3, d);
    chk(d[18] == 1'b0 && d[17] == 1'b1, "R9 error clear keeps done", d[18:17], 2'b01);
    bus_wr(2'd3, ctl | 24'h001000);
    peek(2'd3, d);
    chk(d[17] == 1'b0, "R8 done clear", d[17], 0);

    // R12 control write while idle does update; R8 interrupt
    ctl = mk_ctl(4'd0, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0);
    bus_wr(2'd3, ctl);
    peek(2'd3, d);
    chk(d[10:0] == ctl[10:0], "R12 idle control write", d[10:0], ctl[10:0]);
    bus_wr(2'd0, 24'h000099);
    #1;
    chk(irq == 1'b0, "R8 irq low during transfer", irq, 0);
    wait_idle(cyc);
    chk(irq == 1'b1, "R8 irq after done", irq, 1);
    bus_wr(2'd3, ctl | 24'h001000);
    #1;
    chk(irq == 1'b0, "R8 irq cleared with done", irq, 0);

    // R11 refresh divider
    bus_wr(2'd3, mk_ctl(4'd0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1));
    ref_gap(g);
    chk(g == 8, "R11 refresh period div 0", g, 8);
    bus_wr(2'd3, mk_ctl(4'd3, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1));
    ref_gap(g);
    chk(g == 32, "R11 refresh period div 3", g, 32);
    bus_wr(2'd3, mk_ctl(4'd15, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1));
    ref_gap(g);
    chk(g == 128, "R11 refresh period div 15", g, 128);
    bus_wr(2'd3, mk_ctl(4'd0, 1'b0, 1'b0, 1'b1, 2'd0, 2'd1));
    pulses = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (refresh_req) pulses++;
    end
    chk(pulses == 0, "R11 no refresh in SRAM mode", pulses, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule